// File: doc/BRIEF.md
# Banked Clock Fan-out with Rate Select and Gating

This block distributes one of two incoming clocks to two independent banks of four outputs each. A select input chooses the source. Each bank has its own rate control, which passes either the source frequency or half of it, and its own enable. A disabled bank drives its outputs low and does not float them. Enable and rate changes pass through a synchronizer. They are then applied only while the bank's own source level is low, so a transition never cuts a high or low phase short.

The block is modelled as synchronous logic on an oversampling system clock `sysClk`. The two source clocks are treated as level inputs that are sampled on every `sysClk` edge. Each output pad has a data bit and a drive flag, which together form a three-state output. The pad cell outside the block floats the pin when the drive flag is low. An active-low master input `mrOeN` does two things. It asynchronously clears the divider and all control state, and it drops every drive flag, which puts all eight outputs into high impedance.

Top module: `banked_clk_fanout`

## Requirements
- R1: When `srcSel` is 1 the bank source is `srcB`; when it is 0 the source is `srcA`. A full-rate bank reproduces the sampled source two `sysClk` edges after the source changes.
- R2: The four pads of one bank (pad index bank*4 + 0..3) always carry the same data and drive flag.
- R3: `divSel[b]` = 1 selects full rate and 0 selects half rate. The half-rate divider toggles on every rising edge of the sampled source. After reset the rate state is full rate until the synchronized pin value is applied.
- R4: While bank b's applied enable is 0, its four pads are driven (drive flag 1) with data 0.
- R5: `bankEn[b]` passes through SYNC_STAGES flops. The synchronized value is adopted only in a cycle where that bank's selected source level is low. As a result, no output high or low phase is shorter than the shortest phase of the selected source.
- R6: While `mrOeN` is 0, all drive flags are 0 and the divider, sampler and bank state are cleared. All drive flags become 1 on the first `sysClk` edge after `mrOeN` returns to 1.
- R7: After reset release, the half-rate divider starts low and toggles only on the first true rising source edge that follows. The samplers reset high, so a source that is already high at release does not count as a rising edge. Bank outputs stay low for at least two edges after release.
- R8: A new synchronized `divSel[b]` value is adopted only in a cycle where both the sampled source and bank b's divider level are low.
- R9: The two banks are independent: one bank's rate or enable setting has no effect on the other bank's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Oversampling system clock |
| mrOeN | input | 1 | Active-low master reset and output enable (asynchronous assert) |
| srcA | input | 1 | Single-ended source clock, used when `srcSel` = 0 |
| srcB | input | 1 | Differential-path source clock (already converted), used when `srcSel` = 1 |
| srcSel | input | 1 | Source select |
| divSel | input | NUM_BANKS | Per-bank rate select, 1 = full, 0 = half |
| bankEn | input | NUM_BANKS | Per-bank enable, active high |
| clkOut | output | NUM_BANKS*OUTS_PER_BANK | Pad data, bank-major order |
| clkOutDrive | output | NUM_BANKS*OUTS_PER_BANK | Pad drive flag; 0 means the pin floats |

## Verification
The assertions assume three things about the inputs. Both sources are synchronous to `sysClk`. Every high and low phase of the selected source spans at least two `sysClk` cycles. `srcSel` changes only while `mrOeN` is low, because switching sources on a running clock may legitimately produce a short phase. The stimulus follows all three rules. `srcA` toggles every three cycles and `srcB` every five, and the select is switched only inside a reset window. Enables and rate selects, by contrast, are toggled freely and at any cycle, because the block itself is responsible for keeping those changes runt-free.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  // Strobes from control to datapath, one per bank
  typedef struct packed {
    logic gateOn;    // applied bank enable
    logic fullRate;  // applied rate: 1 = full, 0 = half
  } bankCtl_t;

  // Safe-window indications from datapath back to control
  typedef struct packed {
    logic srcLow;    // this bank's selected level is low this cycle
    logic bothLow;   // sampled source and divider level both low
  } bankView_t;

endpackage

// File: rtl/bclk_ctrl.sv
module bclk_ctrl
  import bclk_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_BANKS-1:0]       bankEnIn,
  input  logic [NUM_BANKS-1:0]       fullSelIn,
  input  bankView_t [NUM_BANKS-1:0]  view,
  output bankCtl_t  [NUM_BANKS-1:0]  ctl
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [SYNC_STAGES-1:0] enChain;
    logic [SYNC_STAGES-1:0] fullChain;
    logic                   enState;
    logic                   fullState;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enChain   <= '0;
        fullChain <= '1;
        enState   <= 1'b0;
        fullState <= 1'b1;
      end else begin
        enChain   <= {enChain[SYNC_STAGES-2:0], bankEnIn[b]};
        fullChain <= {fullChain[SYNC_STAGES-2:0], fullSelIn[b]};
        // enable changes only while the bank level is low
        if (view[b].srcLow)
          enState <= enChain[LAST];
        // rate changes only while both candidate levels are low
        if (view[b].bothLow)
          fullState <= fullChain[LAST];
      end
    end

    assign ctl[b] = '{gateOn: enState, fullRate: fullState};
  end

endmodule

// File: rtl/bclk_datapath.sv
module bclk_datapath
  import bclk_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int OUTS_PER_BANK = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   srcA,
  input  logic                                   srcB,
  input  logic                                   srcSel,
  input  bankCtl_t  [NUM_BANKS-1:0]              ctl,
  output bankView_t [NUM_BANKS-1:0]              view,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0]     padData,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0]     padDrive
);

  logic smpNow;
  logic smpPrev;
  logic riseSeen;
  logic driveOn;

  // Samplers reset high so a level already high at release is not a rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpNow  <= 1'b1;
      smpPrev <= 1'b1;
      driveOn <= 1'b0;
    end else begin
      smpNow  <= srcSel ? srcB : srcA;
      smpPrev <= smpNow;
      driveOn <= 1'b1;
    end
  end

  assign riseSeen = smpNow & ~smpPrev;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic halfQ;
    logic halfNext;
    logic srcLvl;
    logic lvlQ;

    assign halfNext = halfQ ^ riseSeen;
    assign srcLvl   = ctl[b].fullRate ? smpNow : halfNext;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        halfQ <= 1'b0;
        lvlQ  <= 1'b0;
      end else begin
        halfQ <= halfNext;
        lvlQ  <= ctl[b].gateOn & srcLvl;
      end
    end

    assign view[b] = '{srcLow: ~srcLvl, bothLow: ~smpNow & ~halfNext};

    for (genvar o = 0; o < OUTS_PER_BANK; o++) begin : g_pad
      assign padData[b*OUTS_PER_BANK + o]  = lvlQ;
      assign padDrive[b*OUTS_PER_BANK + o] = driveOn;
    end
  end

endmodule

// File: rtl/banked_clk_fanout.sv
module banked_clk_fanout
  import bclk_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int OUTS_PER_BANK = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                                sysClk,
  input  logic                                mrOeN,
  input  logic                                srcA,
  input  logic                                srcB,
  input  logic                                srcSel,
  input  logic [NUM_BANKS-1:0]                divSel,
  input  logic [NUM_BANKS-1:0]                bankEn,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0]  clkOut,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0]  clkOutDrive
);

  bankCtl_t  [NUM_BANKS-1:0] ctl;
  bankView_t [NUM_BANKS-1:0] view;

  bclk_ctrl #(
    .NUM_BANKS   (NUM_BANKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk       (sysClk),
    .rstN      (mrOeN),
    .bankEnIn  (bankEn),
    .fullSelIn (divSel),
    .view      (view),
    .ctl       (ctl)
  );

  bclk_datapath #(
    .NUM_BANKS     (NUM_BANKS),
    .OUTS_PER_BANK (OUTS_PER_BANK)
  ) u_dp (
    .clk      (sysClk),
    .rstN     (mrOeN),
    .srcA     (srcA),
    .srcB     (srcB),
    .srcSel   (srcSel),
    .ctl      (ctl),
    .view     (view),
    .padData  (clkOut),
    .padDrive (clkOutDrive)
  );

endmodule

// File: rtl/bclk_checker.sv
module bclk_checker #(
  parameter int NUM_BANKS     = 2,
  parameter int OUTS_PER_BANK = 4
) (
  input logic                                sysClk,
  input logic                                mrOeN,
  input logic [NUM_BANKS*OUTS_PER_BANK-1:0]  clkOut,
  input logic [NUM_BANKS*OUTS_PER_BANK-1:0]  clkOutDrive
);

  // R6: every pad floats while the master input is low
  always @(posedge sysClk) begin
    if (!mrOeN) begin
      a_r6_float_in_reset: assert (clkOutDrive == '0);
    end
  end

  // R6: pads are driven one edge after release
  a_r6_drive_after_release: assert property (
    @(posedge sysClk) disable iff (!mrOeN)
      mrOeN |=> (&clkOutDrive));

  // R7: outputs stay low right after release
  a_r7_low_after_release: assert property (
    @(posedge sysClk) disable iff (!mrOeN)
      $rose(mrOeN) |=> (clkOut == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // R5: no single-cycle high phase
    a_r5_high_min: assert property (
      @(posedge sysClk) disable iff (!mrOeN)
        $rose(clkOut[b*OUTS_PER_BANK]) |=> clkOut[b*OUTS_PER_BANK]);
    // R5: no single-cycle low phase
    a_r5_low_min: assert property (
      @(posedge sysClk) disable iff (!mrOeN)
        $fell(clkOut[b*OUTS_PER_BANK]) |=> !clkOut[b*OUTS_PER_BANK]);
  end

endmodule

bind banked_clk_fanout bclk_checker #(
  .NUM_BANKS     (NUM_BANKS),
  .OUTS_PER_BANK (OUTS_PER_BANK)
) u_chk (
  .sysClk      (sysClk),
  .mrOeN       (mrOeN),
  .clkOut      (clkOut),
  .clkOutDrive (clkOutDrive)
);

// File: tb/banked_clk_fanout_tb.sv
module banked_clk_fanout_tb;

  localparam int NB   = 2;
  localparam int NO   = 4;
  localparam int NP   = NB * NO;
  localparam int SYNC = 2;
  localparam int MINW = 3;
  localparam int A_HALF = 3;
  localparam int B_HALF = 5;

  typedef bit bq_t[$];

  logic sysClk = 1'b0;
  always #4 sysClk = ~sysClk;

  logic          mrOeN, srcA, srcB, srcSel;
  logic [NB-1:0] divSel, bankEn;
  logic [NP-1:0] clkOut, clkOutDrive;

  banked_clk_fanout #(
    .NUM_BANKS(NB), .OUTS_PER_BANK(NO), .SYNC_STAGES(SYNC)
  ) u_dut (
    .sysClk(sysClk), .mrOeN(mrOeN), .srcA(srcA), .srcB(srcB),
    .srcSel(srcSel), .divSel(divSel), .bankEn(bankEn),
    .clkOut(clkOut), .clkOutDrive(clkOutDrive)
  );

  int    compared = 0;
  int    mismatched = 0;
  string curReq = "R6";
  int    aCnt = 0, bCnt = 0;
  bit    done = 0;

  // behavioural reference state
  bit  mS = 1, mSPrev = 1, mOe = 0;
  bit  mHalf[NB], mOut[NB], mEn[NB], mFull[NB];
  bq_t enQ[NB];
  bq_t divQ[NB];

  int runLen[NB];
  bit runFirst[NB];
  bit lastLvl[NB];
  int riseCnt[NB];
  bit prevLvl[NB];

  task automatic fail(string req, string what, int act, int exp);
    mismatched++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic modelStep();
    bit rise, hn, lvl, enOld, divOld;
    if (!mrOeN) begin
      mS = 1; mSPrev = 1; mOe = 0;
      for (int b = 0; b < NB; b++) begin
        mHalf[b] = 0; mOut[b] = 0; mEn[b] = 0; mFull[b] = 1;
        enQ[b] = {}; divQ[b] = {};
        repeat (SYNC) begin enQ[b].push_back(1'b0); divQ[b].push_back(1'b1); end
      end
    end else begin
      rise = mS & !mSPrev;
      for (int b = 0; b < NB; b++) begin
        hn     = mHalf[b] ^ rise;
        lvl    = mFull[b] ? mS : hn;
        enOld  = enQ[b][0];
        divOld = divQ[b][0];
        mOut[b] = mEn[b] & lvl;
        if (!lvl) mEn[b] = enOld;
        if (!mS && !hn) mFull[b] = divOld;
        mHalf[b] = hn;
        void'(enQ[b].pop_front());  enQ[b].push_back(bankEn[b]);
        void'(divQ[b].pop_front()); divQ[b].push_back(divSel[b]);
      end
      mSPrev = mS;
      mS     = srcSel ? srcB : srcA;
      mOe    = 1;
    end
  endtask

  task automatic checkOuts();
    int act, exp;
    bit lvl;
    for (int p = 0; p < NP; p++) begin
      act = clkOutDrive[p] ? int'(clkOut[p]) : 2;
      exp = !mOe ? 2 : int'(mOut[p / NO]);
      compared++;
      if (act != exp) fail(curReq, $sformatf("pad %0d", p), act, exp);
    end
    for (int b = 0; b < NB; b++) begin
      // R2: bank pads identical
      compared++;
      if (clkOut[b*NO +: NO] != {NO{clkOut[b*NO]}} ||
          clkOutDrive[b*NO +: NO] != {NO{clkOutDrive[b*NO]}})
        fail("R2", $sformatf("bank %0d pads", b), int'(clkOut[b*NO +: NO]), int'({NO{clkOut[b*NO]}}));
      lvl = clkOut[b*NO];
      if (!mrOeN || !clkOutDrive[b*NO]) begin
        runLen[b] = 0; runFirst[b] = 1; prevLvl[b] = 0;
      end else begin
        if (lvl && !prevLvl[b]) riseCnt[b]++;
        prevLvl[b] = lvl;
        if (runLen[b] == 0) begin
          runLen[b] = 1; lastLvl[b] = lvl;
        end else if (lvl == lastLvl[b]) begin
          runLen[b]++;
        end else begin
          if (!runFirst[b]) begin
            compared++;   // R5: phase width
            if (runLen[b] < MINW) fail("R5", $sformatf("bank %0d phase width", b), runLen[b], MINW);
          end
          runFirst[b] = 0; runLen[b] = 1; lastLvl[b] = lvl;
        end
      end
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      modelStep();
      @(negedge sysClk);
      checkOuts();
      aCnt++; if (aCnt == A_HALF) begin srcA = ~srcA; aCnt = 0; end
      bCnt++; if (bCnt == B_HALF) begin srcB = ~srcB; bCnt = 0; end
    end
  endtask

  task automatic clearRise();
    for (int b = 0; b < NB; b++) riseCnt[b] = 0;
  endtask

  task automatic rangeCheck(string req, string what, int v, int lo, int hi);
    compared++;
    if (v < lo || v > hi) fail(req, what, v, (lo + hi) / 2);
  endtask

  task automatic checkFloat(string req);
    compared++;
    if (clkOutDrive != '0) fail(req, "drive flags in reset", int'(clkOutDrive), 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    mrOeN = 0; srcA = 0; srcB = 0; srcSel = 0; divSel = '1; bankEn = '1;
    for (int b = 0; b < NB; b++) begin runFirst[b] = 1; runLen[b] = 0; end
    clearRise();

    // R6: reset floats everything
    curReq = "R6"; tick(6);
    checkFloat("R6");

    // R1: full rate on srcA (period 6)
    mrOeN = 1; curReq = "R1"; tick(8);
    clearRise(); tick(120);
    rangeCheck("R1", "bank0 rises on srcA", riseCnt[0], 19, 21);
    rangeCheck("R9", "bank1 rises on srcA", riseCnt[1], 19, 21);

    // R3 / R8: bank 0 to half rate, bank 1 untouched
    divSel[0] = 0; curReq = "R8"; tick(20);
    curReq = "R3"; clearRise(); tick(120);
    rangeCheck("R3", "bank0 half-rate rises", riseCnt[0], 9, 11);
    rangeCheck("R9", "bank1 full-rate rises", riseCnt[1], 19, 21);

    // R4: disable bank 1, it must be driven low
    bankEn[1] = 0; curReq = "R4"; tick(20);
    compared++;
    if (clkOut[NP-1 -: NO] != '0 || clkOutDrive[NP-1 -: NO] != '1)
      fail("R4", "disabled bank pads", int'(clkOut[NP-1 -: NO]), 0);
    tick(40);

    // R9: swap rates between banks
    bankEn[1] = 1; divSel = 2'b01; curReq = "R9"; tick(80);

    // R6 then R7: reset, switch to srcB, release in half rate on bank 1
    mrOeN = 0; curReq = "R6"; tick(3);
    checkFloat("R6");
    srcSel = 1; divSel = 2'b01; tick(2);
    mrOeN = 1; curReq = "R7"; tick(40);
    curReq = "R1"; clearRise(); tick(200);
    rangeCheck("R1", "bank0 rises on srcB", riseCnt[0], 19, 21);
    rangeCheck("R3", "bank1 half-rate rises on srcB", riseCnt[1], 9, 11);

    // R5: enables toggled at arbitrary cycles
    curReq = "R5";
    for (int k = 0; k < 30; k++) begin
      bankEn = ~bankEn; tick(2 + (k % 4));
    end
    bankEn = '1; tick(30);

    // R8: rate selects toggled at arbitrary cycles
    curReq = "R8";
    for (int k = 0; k < 12; k++) begin
      divSel[k % 2] = ~divSel[k % 2]; tick(3 + (k % 5));
    end
    tick(40);

    // R6: mid-run reset
    mrOeN = 0; curReq = "R6"; tick(4);
    checkFloat("R6");
    mrOeN = 1; curReq = "R7"; tick(30);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule